// File: doc/BRIEF.md
# Slave FIFO Write Sequencer

This block sits on the external-master side of a synchronous slave FIFO port and streams bytes into it. An internal source presents bytes on a valid/ready handshake. Each byte comes with a target FIFO address and a flag that marks the byte as the last one of the packet. The sequencer drives the FIFO address lines, a chip-select, a write strobe, the data bus and a packet-end strobe. All of these outputs are registered and active-high.

The sequencer inserts a programmable number of address setup cycles whenever it has to move to a new address. It raises chip-select before the first write strobe of a packet. It then writes one byte per clock for as long as the source keeps supplying bytes. It stops writing while the slave reports full. The slave commits a packet on its own when it reaches the auto-commit length, and the sequencer keeps a byte count modulo that length. It uses this count for two things. It does not send a redundant packet-end when a packet closes exactly on an auto-commit. It also delays packet-end by one cycle when a one-byte manual packet directly follows an auto-committed packet.

Top module: `slave_fifo_writer`

## Requirements
- R1: While rstN is low (asynchronous, active-low), fifoCs, fifoWr, fifoPktEnd and srcReady are 0 and fifoAddr is 0. After reset, no address counts as held.
- R2: A packet whose srcAddr differs from the held address, or that is the first packet after reset, loads fifoAddr. SETUP_CYC full cycles (default 2) then pass with fifoCs and srcReady low before fifoCs rises.
- R3: A packet whose srcAddr equals the held address skips setup. fifoCs rises in the cycle after the one in which idle saw srcValid.
- R4: fifoCs is high in the cycle before the first fifoWr of a packet, and fifoCs is high in every cycle in which fifoWr is high.
- R5: In the write phase srcReady equals !fifoFull. Each handshake drives fifoWr high in the next cycle, with fifoData equal to the accepted byte. Back-to-back handshakes produce a burst of one byte per cycle.
- R6: While fifoFull is high, srcReady is low. fifoWr is low in the following cycle and fifoCs stays high.
- R7: When the byte flagged srcLast is written, fifoPktEnd is high in the same cycle as its fifoWr, unless R8 or R9 applies.
- R8: A srcLast byte that is the first byte after a write which completed AUTO_LEN bytes (default 4) gets no fifoPktEnd with its write. fifoPktEnd instead comes in the following cycle, with fifoCs high and fifoWr low.
- R9: The byte count covers the bytes written since the last commit, modulo AUTO_LEN. A srcLast byte that brings this count to AUTO_LEN produces no fifoPktEnd at all.
- R10: fifoAddr changes only in cycles where fifoCs was low in the previous cycle. fifoAddr is stable in every cycle in which fifoPktEnd is high.
- R11: After the last write or packet-end of a packet, fifoCs is low for at least one cycle before it rises again or fifoAddr changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the slave port |
| rstN | input | 1 | Asynchronous active-low reset |
| srcValid | input | 1 | Source byte available |
| srcReady | output | 1 | Sequencer takes the byte this cycle |
| srcData | input | DATA_W | Byte from the source |
| srcLast | input | 1 | Byte closes the current packet |
| srcAddr | input | ADDR_W | Target FIFO address for the packet |
| fifoFull | input | 1 | Slave full flag, raised with one byte of room left |
| fifoAddr | output | ADDR_W | FIFO address lines |
| fifoCs | output | 1 | Chip-select, active-high |
| fifoWr | output | 1 | Write strobe, active-high |
| fifoData | output | DATA_W | Write data bus |
| fifoPktEnd | output | 1 | Packet-end strobe, active-high |

## Verification
The properties assume two things about the inputs. srcAddr and srcLast carry meaning only while srcValid is high. fifoFull may change in any cycle, because the sequencer only samples it. The stimulus keeps srcAddr constant for the whole of a packet. It presents each byte until that byte is taken, and it raises fifoFull only inside a burst. Under these conditions every cycle of the walked trace has one defined expected output. The setup-window property counts cycles since the last address change, so it stays valid for any SETUP_CYC.

// File: rtl/slave_fifo_writer_pkg.sv
`timescale 1ns/1ps
package slave_fifo_writer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WRITE,
    ST_PKTEND,
    ST_GAP
  } wrState_t;

  // strobes from control to datapath, each registered into a pad output
  typedef struct packed {
    logic loadAddr;
    logic loadData;
    logic csNext;
    logic wrNext;
    logic pktNext;
  } wrStrobes_t;

endpackage

// File: rtl/slave_fifo_writer_ctrl.sv
`timescale 1ns/1ps
module slave_fifo_writer_ctrl
  import slave_fifo_writer_pkg::*;
#(
  parameter int AUTO_LEN  = 4,
  parameter int SETUP_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       srcValid,
  input  logic       srcLast,
  input  logic       fifoFull,
  input  logic       addrMatch,
  output logic       srcReady,
  output wrStrobes_t strb
);

  localparam int CNT_W = (AUTO_LEN > 1) ? $clog2(AUTO_LEN) : 1;
  localparam int SET_W = (SETUP_CYC > 0) ? $clog2(SETUP_CYC + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(AUTO_LEN - 1);
  localparam logic [SET_W-1:0] SET_LOAD = SET_W'(SETUP_CYC - 1);

  wrState_t         state, stateNext;
  logic [CNT_W-1:0] byteCnt;
  logic             prevWrapped;
  logic [SET_W-1:0] setCnt;
  logic             accept, wrapNow, holdOff, pktNow, loadAddr;

  assign accept   = (state == ST_WRITE) && srcValid && !fifoFull;
  assign srcReady = (state == ST_WRITE) && !fifoFull;
  assign wrapNow  = (byteCnt == CNT_LAST);
  // first byte after a write that completed an auto-length packet
  assign holdOff  = prevWrapped && (byteCnt == '0);

  always_comb begin
    stateNext = state;
    loadAddr  = 1'b0;
    pktNow    = 1'b0;
    case (state)
      ST_IDLE: if (srcValid) begin
        if (addrMatch) stateNext = ST_WRITE;
        else begin
          loadAddr  = 1'b1;
          stateNext = ST_SETUP;
        end
      end
      ST_SETUP:  if (setCnt == '0) stateNext = ST_WRITE;
      ST_WRITE:  if (accept && srcLast) begin
        stateNext = holdOff ? ST_PKTEND : ST_GAP;
        pktNow    = !holdOff && !wrapNow;
      end
      ST_PKTEND: begin
        pktNow    = 1'b1;
        stateNext = ST_GAP;
      end
      ST_GAP:    stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.loadAddr = loadAddr;
    strb.loadData = accept;
    strb.wrNext   = accept;
    strb.pktNext  = pktNow;
    strb.csNext   = accept || (stateNext == ST_WRITE) ||
                    (stateNext == ST_PKTEND) || (state == ST_PKTEND);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      byteCnt     <= '0;
      prevWrapped <= 1'b0;
      setCnt      <= '0;
    end else begin
      state <= stateNext;
      if (loadAddr) setCnt <= SET_LOAD;
      else if (state == ST_SETUP && setCnt != '0) setCnt <= setCnt - 1'b1;
      if (accept) begin
        prevWrapped <= wrapNow;
        if (srcLast || wrapNow) byteCnt <= '0;
        else byteCnt <= byteCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/slave_fifo_writer_dp.sv
`timescale 1ns/1ps
module slave_fifo_writer_dp
  import slave_fifo_writer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobes_t        strb,
  input  logic [DATA_W-1:0] srcData,
  input  logic [ADDR_W-1:0] srcAddr,
  output logic              addrMatch,
  output logic [ADDR_W-1:0] fifoAddr,
  output logic              fifoCs,
  output logic              fifoWr,
  output logic [DATA_W-1:0] fifoData,
  output logic              fifoPktEnd
);

  logic addrValid;

  assign addrMatch = addrValid && (srcAddr == fifoAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrValid  <= 1'b0;
      fifoAddr   <= '0;
      fifoData   <= '0;
      fifoCs     <= 1'b0;
      fifoWr     <= 1'b0;
      fifoPktEnd <= 1'b0;
    end else begin
      if (strb.loadAddr) begin
        fifoAddr  <= srcAddr;
        addrValid <= 1'b1;
      end
      if (strb.loadData) fifoData <= srcData;
      fifoCs     <= strb.csNext;
      fifoWr     <= strb.wrNext;
      fifoPktEnd <= strb.pktNext;
    end
  end

endmodule

// File: rtl/slave_fifo_writer.sv
`timescale 1ns/1ps
module slave_fifo_writer
  import slave_fifo_writer_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int AUTO_LEN  = 4,
  parameter int SETUP_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcValid,
  output logic              srcReady,
  input  logic [DATA_W-1:0] srcData,
  input  logic              srcLast,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic              fifoFull,
  output logic [ADDR_W-1:0] fifoAddr,
  output logic              fifoCs,
  output logic              fifoWr,
  output logic [DATA_W-1:0] fifoData,
  output logic              fifoPktEnd
);

  wrStrobes_t strb;
  logic       addrMatch;

  slave_fifo_writer_ctrl #(.AUTO_LEN(AUTO_LEN), .SETUP_CYC(SETUP_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcLast(srcLast),
    .fifoFull(fifoFull), .addrMatch(addrMatch), .srcReady(srcReady), .strb(strb)
  );

  slave_fifo_writer_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcData(srcData), .srcAddr(srcAddr),
    .addrMatch(addrMatch), .fifoAddr(fifoAddr), .fifoCs(fifoCs), .fifoWr(fifoWr),
    .fifoData(fifoData), .fifoPktEnd(fifoPktEnd)
  );

endmodule

// File: rtl/slave_fifo_writer_chk.sv
`timescale 1ns/1ps
module slave_fifo_writer_chk #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int SETUP_CYC = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              srcValid,
  input logic              srcReady,
  input logic [DATA_W-1:0] srcData,
  input logic              fifoFull,
  input logic [ADDR_W-1:0] fifoAddr,
  input logic              fifoCs,
  input logic              fifoWr,
  input logic [DATA_W-1:0] fifoData,
  input logic              fifoPktEnd
);

  localparam int AGE_W = $clog2(SETUP_CYC + 2) + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [ADDR_W-1:0] lastAddr;
  logic [AGE_W-1:0]  addrAge;

  // cycles since fifoAddr last changed value, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastAddr <= '0;
      addrAge  <= AGE_MAX;
    end else begin
      lastAddr <= fifoAddr;
      if (fifoAddr != lastAddr) addrAge <= AGE_W'(1);
      else if (addrAge != AGE_MAX) addrAge <= addrAge + 1'b1;
    end
  end

  a_r2_setup_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoCs) |-> (addrAge >= AGE_W'(SETUP_CYC)));

  a_r4_wr_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    fifoWr |-> fifoCs);

  a_r4_cs_leads_wr: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoWr) |-> $past(fifoCs));

  a_r5_handshake_writes: assert property (@(posedge clk) disable iff (!rstN)
    (srcValid && srcReady) |=> (fifoWr && fifoData == $past(srcData)));

  a_r6_full_stops_wr: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |=> !fifoWr);

  a_r10_addr_stable_pktend: assert property (@(posedge clk) disable iff (!rstN)
    fifoPktEnd |-> $stable(fifoAddr));

  a_r10_addr_only_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    $changed(fifoAddr) |-> (!$past(fifoCs) && !fifoCs));

endmodule

bind slave_fifo_writer slave_fifo_writer_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcReady(srcReady),
  .srcData(srcData), .fifoFull(fifoFull), .fifoAddr(fifoAddr), .fifoCs(fifoCs),
  .fifoWr(fifoWr), .fifoData(fifoData), .fifoPktEnd(fifoPktEnd)
);

// File: tb/slave_fifo_writer_bench.sv
`timescale 1ns/1ps
module slave_fifo_writer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       srcValid = 1'b0, srcLast = 1'b0, fifoFull = 1'b0;
  logic [7:0] srcData = '0;
  logic [1:0] srcAddr = '0;
  logic       srcReady, fifoCs, fifoWr, fifoPktEnd;
  logic [7:0] fifoData;
  logic [1:0] fifoAddr;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  slave_fifo_writer u_slave_fifo_writer (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcReady(srcReady),
    .srcData(srcData), .srcLast(srcLast), .srcAddr(srcAddr), .fifoFull(fifoFull),
    .fifoAddr(fifoAddr), .fifoCs(fifoCs), .fifoWr(fifoWr), .fifoData(fifoData),
    .fifoPktEnd(fifoPktEnd)
  );

  typedef struct packed {
    logic v, l, f;
    logic [1:0] a;
    logic [7:0] d;
    logic eR, eC, eW, eP;
    logic [1:0] eA;
    logic [7:0] eD;
  } row_t;

  function automatic row_t mk(logic v, logic l, logic f, logic [1:0] a, logic [7:0] d,
                              logic eR, logic eC, logic eW, logic eP,
                              logic [1:0] eA, logic [7:0] eD);
    return '{v:v, l:l, f:f, a:a, d:d, eR:eR, eC:eC, eW:eW, eP:eP, eA:eA, eD:eD};
  endfunction

  localparam int NROWS = 33;
  // per cycle: inputs, then outputs expected in that cycle (AUTO_LEN 4, SETUP_CYC 2)
  localparam row_t ROWS [NROWS] = '{
    mk(1,1,0,1,8'h11, 0,0,0,0,0,8'h00), // 0  new address: setup (R2)
    mk(1,1,0,1,8'h11, 0,0,0,0,1,8'h00),
    mk(1,1,0,1,8'h11, 0,0,0,0,1,8'h00),
    mk(1,1,0,1,8'h11, 1,1,0,0,1,8'h00), // 3  cs first, byte taken
    mk(0,0,0,1,8'h00, 0,1,1,1,1,8'h11), // 4  one-byte packet, pktEnd with byte (R7)
    mk(0,0,0,1,8'h00, 0,0,0,0,1,8'h00), // 5  idle gap (R11)
    mk(1,0,0,1,8'hA0, 0,0,0,0,1,8'h00), // 6  same address, no setup (R3)
    mk(1,0,0,1,8'hA0, 1,1,0,0,1,8'h00),
    mk(1,0,0,1,8'hA1, 1,1,1,0,1,8'hA0), // 8  burst
    mk(1,0,1,1,8'hA2, 0,1,1,0,1,8'hA1), // 9  full (R6)
    mk(1,0,0,1,8'hA2, 1,1,0,0,1,8'h00),
    mk(1,0,0,1,8'hA3, 1,1,1,0,1,8'hA2),
    mk(1,0,0,1,8'hA4, 1,1,1,0,1,8'hA3),
    mk(1,1,0,1,8'hA5, 1,1,1,0,1,8'hA4),
    mk(0,0,0,1,8'h00, 0,1,1,1,1,8'hA5), // 14 six bytes: pktEnd with last
    mk(0,0,0,1,8'h00, 0,0,0,0,1,8'h00),
    mk(1,0,0,1,8'hB0, 0,0,0,0,1,8'h00),
    mk(1,0,0,1,8'hB0, 1,1,0,0,1,8'h00),
    mk(1,0,0,1,8'hB1, 1,1,1,0,1,8'hB0),
    mk(1,0,0,1,8'hB2, 1,1,1,0,1,8'hB1),
    mk(1,0,0,1,8'hB3, 1,1,1,0,1,8'hB2),
    mk(1,1,0,1,8'hC0, 1,1,1,0,1,8'hB3), // 21 one-byte packet after auto commit
    mk(0,0,0,1,8'h00, 0,1,1,0,1,8'hC0), // 22 byte written, no pktEnd (R8)
    mk(0,0,0,1,8'h00, 0,1,0,1,1,8'h00), // 23 pktEnd one cycle later (R8)
    mk(1,0,0,2,8'hD0, 0,0,0,0,1,8'h00), // 24 new address after gap
    mk(1,0,0,2,8'hD0, 0,0,0,0,2,8'h00),
    mk(1,0,0,2,8'hD0, 0,0,0,0,2,8'h00),
    mk(1,0,0,2,8'hD0, 1,1,0,0,2,8'h00),
    mk(1,0,0,2,8'hD1, 1,1,1,0,2,8'hD0),
    mk(1,0,0,2,8'hD2, 1,1,1,0,2,8'hD1),
    mk(1,1,0,2,8'hD3, 1,1,1,0,2,8'hD2),
    mk(0,0,0,2,8'h00, 0,1,1,0,2,8'hD3), // 31 last completes auto length (R9)
    mk(0,0,0,2,8'h00, 0,0,0,0,2,8'h00)
  };

  task automatic check(string tag, string what, int row, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, row, act, exp);
    end
  endtask

  function automatic string csTag(int i);
    case (i)
      1, 2, 25, 26: return "R2";
      7:            return "R3";
      5, 15, 24, 32: return "R11";
      default:      return "R4";
    endcase
  endfunction

  function automatic string pktTag(int i);
    case (i)
      22, 23: return "R8";
      30, 31: return "R9";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1", "cs in reset", -1, fifoCs, 0);
    check("R1", "wr in reset", -1, fifoWr, 0);
    check("R1", "pktEnd in reset", -1, fifoPktEnd, 0);
    check("R1", "addr in reset", -1, fifoAddr, 0);
    check("R1", "ready in reset", -1, srcReady, 0);
    rstN = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      srcValid = ROWS[i].v; srcLast = ROWS[i].l; fifoFull = ROWS[i].f;
      srcAddr  = ROWS[i].a; srcData = ROWS[i].d;
      #1;
      check(ROWS[i].f ? "R6" : "R5", "srcReady", i, srcReady, ROWS[i].eR);
      check(csTag(i), "fifoCs", i, fifoCs, ROWS[i].eC);
      check("R5", "fifoWr", i, fifoWr, ROWS[i].eW);
      check(pktTag(i), "fifoPktEnd", i, fifoPktEnd, ROWS[i].eP);
      check("R10", "fifoAddr", i, fifoAddr, ROWS[i].eA);
      if (ROWS[i].eW) check("R5", "fifoData", i, fifoData, ROWS[i].eD);
      @(negedge clk);
    end

    // reset in the middle of a burst (R1)
    srcValid = 1'b1; srcLast = 1'b0; srcAddr = 2'd2; srcData = 8'h5A;
    repeat (3) @(negedge clk);
    check("R1", "cs before mid reset", 100, fifoCs, 1);
    rstN = 1'b0;
    #1;
    check("R1", "cs after mid reset", 100, fifoCs, 0);
    check("R1", "wr after mid reset", 100, fifoWr, 0);
    check("R1", "addr after mid reset", 100, fifoAddr, 0);
    check("R1", "ready after mid reset", 100, srcReady, 0);
    @(negedge clk);
    rstN = 1'b1;

    // first packet after reset to address 0 still gets setup (R2)
    srcAddr = 2'd0; srcData = 8'h77; srcLast = 1'b1; srcValid = 1'b1;
    @(negedge clk); #1;
    check("R2", "cs setup cycle 1", 101, fifoCs, 0);
    @(negedge clk); #1;
    check("R2", "cs setup cycle 2", 102, fifoCs, 0);
    check("R2", "ready during setup", 102, srcReady, 0);
    @(negedge clk); #1;
    check("R2", "cs after setup", 103, fifoCs, 1);
    check("R5", "ready after setup", 103, srcReady, 1);
    @(negedge clk); srcValid = 1'b0; #1;
    check("R7", "pktEnd one-byte", 104, fifoPktEnd, 1);
    check("R5", "data one-byte", 104, fifoData, 8'h77);
    @(negedge clk); #1;
    check("R11", "cs gap", 105, fifoCs, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule